// File: doc/BRIEF.md
# Reference Clock Ratio Detector

This block decides, continuously and without any configuration input, how the incoming reference clock relates to the local oscillator. The oscillator runs near the line rate (roughly 2.49 to 2.7 GHz), and the reference is supplied at one sixteenth, one thirty-second or one hundred-and-twenty-eighth of it. The block runs on a measurement clock that is the oscillator divided by `MEAS_DIV`. It counts rising edges of the synchronised reference over back-to-back windows of `WIN_CYCLES` measurement cycles. It then sorts each window's count into one of three bands and drives a divider select, so that the loop divider compares the oscillator against the reference at the right ratio.

Band edges sit at the geometric midpoints between neighbouring ratios: an oscillator-to-reference ratio of about 22.6 between 16 and 32, and 64 between 32 and 128. With the defaults (256-cycle window, divide-by-4 measurement clock, so 1024 oscillator cycles per window) the upper edge-count threshold is 45 and the lower one is 16. A new band is adopted only after two consecutive windows agree. A window with no reference edge at all marks the reference as absent at once, so that a downstream lock alarm can be forced.

Top module: `ref_ratio_detect`

## Requirements
- R1: While `rst` is high, and after it, until a window says otherwise, `ratio_sel` is 2'b11, `ratio_valid` is 0 and `ref_active` is 0.
- R2: Windows of `WIN_CYCLES` measurement cycles run back to back from the first cycle after reset. Each window counts rising edges of `ref_clk` after a `SYNC_STAGES`-flop synchroniser, and its verdict reaches the outputs two cycles after the window's last cycle.
- R3: A window count above 45 (ratio below about 22.6) classifies as the divide-by-16 band, select code 2'b00.
- R4: A window count from 17 to 45 inclusive classifies as the divide-by-32 band, select code 2'b01.
- R5: A window count from 1 to 16 inclusive (ratio of 64 or more) classifies as the divide-by-128 band, select code 2'b10.
- R6: `ratio_sel` changes to a band code only when two consecutive windows give that same band. A single window of another band leaves it unchanged.
- R7: A window with zero edges drives `ref_active` low, `ratio_sel` to 2'b11 and `ratio_valid` low at that window's verdict, without waiting for a second window.
- R8: When the reference returns, `ref_active` rises at the first window with a nonzero count. `ratio_valid` rises only at a later window, a whole number of windows after that.
- R9: `ratio_valid` is high exactly when `ratio_sel` holds a band code, and it is never high while `ref_active` is low.
- R10: Monitoring never stops: a lasting change of reference frequency moves `ratio_sel` to the new band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measurement clock (oscillator divided by `MEAS_DIV`) |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference clock, asynchronous to `clk` |
| ratio_sel | output | 2 | Divider select: 00 = 16, 01 = 32, 10 = 128, 11 = none |
| ratio_valid | output | 1 | High when `ratio_sel` holds a confirmed band |
| ref_active | output | 1 | High when the last window saw reference edges |

## Verification
The hardest situations to reach are a short excursion into another band that straddles a window boundary, and a reference that returns in the middle of a window. The partial windows these produce must not confirm a wrong band, and they stretch the time until the select becomes valid. The stimulus drives the reference with programmable high and low lengths. It injects a burst of divide-by-16 rate lasting half a window into a steady divide-by-32 reference, so that neither straddled window can reach the upper band twice in a row. It also stops and restarts the reference at arbitrary phases, and periods of 5, 6, 15 and 16 cycles place window counts on each side of both thresholds.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    // Widest window edge count carried between stages
    localparam int MEAS_CNT_W = 16;

    typedef enum logic [1:0] {
        SEL_DIV16  = 2'b00,
        SEL_DIV32  = 2'b01,
        SEL_DIV128 = 2'b10,
        SEL_NONE   = 2'b11
    } ratio_sel_e;

    typedef struct packed {
        logic                  done;
        logic [MEAS_CNT_W-1:0] edges;
    } meas_s;

    typedef struct packed {
        ratio_sel_e sel;
        logic       valid;
        logic       active;
    } status_s;

    // Edge-count boundary for a ratio of sqrt(16*32) ~= 22.627
    function automatic int upper_threshold(int osc_per_win);
        longint scaled;
        scaled = longint'(osc_per_win) * 64'sd1000;
        return int'(scaled / 64'sd22627);
    endfunction

    // Edge-count boundary for a ratio of sqrt(32*128) = 64
    function automatic int lower_threshold(int osc_per_win);
        return osc_per_win / 64;
    endfunction

    function automatic ratio_sel_e classify(logic [MEAS_CNT_W-1:0] edges, int hi, int lo);
        int n;
        n = int'(edges);
        if (n == 0)       return SEL_NONE;
        else if (n > hi)  return SEL_DIV16;
        else if (n > lo)  return SEL_DIV32;
        else              return SEL_DIV128;
    endfunction

endpackage

// File: rtl/rcd_edge_sync.sv
module rcd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_clk,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= ref_clk;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b0;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b0;
        else     hist_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~hist_q;
endmodule

// File: rtl/rcd_window_counter.sv
module rcd_window_counter
    import rcd_pkg::*;
#(
    parameter int WIN_CYCLES = 256
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rise,
    output meas_s meas
);
    localparam int TW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam int CW = $clog2(WIN_CYCLES + 1);

    logic [TW-1:0] tick_q;
    logic [CW-1:0] acc_q;
    logic [CW-1:0] acc_next;
    logic          last_tick;
    meas_s         meas_q;

    assign last_tick = (tick_q == TW'(WIN_CYCLES - 1));
    assign acc_next  = acc_q + CW'(rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            acc_q  <= '0;
            meas_q <= '0;
        end else begin
            meas_q.done <= last_tick;
            if (last_tick) begin
                tick_q       <= '0;
                acc_q        <= '0;
                meas_q.edges <= MEAS_CNT_W'(acc_next);
            end else begin
                tick_q <= tick_q + 1'b1;
                acc_q  <= acc_next;
            end
        end
    end

    assign meas = meas_q;
endmodule

// File: rtl/rcd_band_filter.sv
module rcd_band_filter
    import rcd_pkg::*;
#(
    parameter int HI_THR = 45,
    parameter int LO_THR = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  meas_s   meas,
    output status_s status
);
    ratio_sel_e cand_q;
    ratio_sel_e verdict;
    status_s    stat_q;

    always_comb verdict = classify(meas.edges, HI_THR, LO_THR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= SEL_NONE;
            stat_q <= '{sel: SEL_NONE, valid: 1'b0, active: 1'b0};
        end else if (meas.done) begin
            cand_q <= verdict;
            if (verdict == SEL_NONE) begin
                stat_q.sel    <= SEL_NONE;
                stat_q.valid  <= 1'b0;
                stat_q.active <= 1'b0;
            end else begin
                stat_q.active <= 1'b1;
                if (verdict == cand_q) begin
                    stat_q.sel   <= verdict;
                    stat_q.valid <= 1'b1;
                end
            end
        end
    end

    assign status = stat_q;
endmodule

// File: rtl/ref_ratio_detect.sv
module ref_ratio_detect
    import rcd_pkg::*;
#(
    parameter int WIN_CYCLES  = 256,
    parameter int MEAS_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_clk,
    output logic [1:0] ratio_sel,
    output logic       ratio_valid,
    output logic       ref_active
);
    localparam int OSC_PER_WIN = WIN_CYCLES * MEAS_DIV;
    localparam int HI_THR      = upper_threshold(OSC_PER_WIN);
    localparam int LO_THR      = lower_threshold(OSC_PER_WIN);

    logic    rise_w;
    meas_s   meas_w;
    status_s stat_w;

    rcd_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .ref_clk (ref_clk),
        .rise    (rise_w)
    );

    rcd_window_counter #(.WIN_CYCLES(WIN_CYCLES)) win_i (
        .clk  (clk),
        .rst  (rst),
        .rise (rise_w),
        .meas (meas_w)
    );

    rcd_band_filter #(.HI_THR(HI_THR), .LO_THR(LO_THR)) filt_i (
        .clk    (clk),
        .rst    (rst),
        .meas   (meas_w),
        .status (stat_w)
    );

    assign ratio_sel   = stat_w.sel;
    assign ratio_valid = stat_w.valid;
    assign ref_active  = stat_w.active;
endmodule

// File: rtl/rcd_checker.sv
module rcd_checker (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  ratio_sel,
    input logic        ratio_valid,
    input logic        ref_active,
    input logic        meas_done,
    input logic [15:0] meas_edges
);
    // R9
    valid_code_chk: assert property (@(posedge clk) disable iff (rst)
        ratio_valid |-> (ratio_sel != 2'b11));

    // R9
    valid_active_chk: assert property (@(posedge clk) disable iff (rst)
        ratio_valid |-> ref_active);

    // R6
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !meas_done |=> $stable(ratio_sel));

    // R7
    absent_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (meas_done && meas_edges == 16'd0) |=> (!ref_active && !ratio_valid && ratio_sel == 2'b11));

    // R8
    active_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (meas_done && meas_edges != 16'd0) |=> ref_active);
endmodule

bind ref_ratio_detect rcd_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .ratio_sel   (ratio_sel),
    .ratio_valid (ratio_valid),
    .ref_active  (ref_active),
    .meas_done   (meas_w.done),
    .meas_edges  (meas_w.edges)
);

// File: tb/ref_ratio_detect_tb_top.sv
module ref_ratio_detect_tb_top;
    localparam int WIN  = 256;
    localparam int DIV  = 4;
    localparam int SYNC = 2;
    localparam int HI   = 45;
    localparam int LO   = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_clk = 1'b0;
    logic [1:0] ratio_sel;
    logic       ratio_valid;
    logic       ref_active;

    int compared = 0;
    int mismatched = 0;

    ref_ratio_detect #(.WIN_CYCLES(WIN), .MEAS_DIV(DIV), .SYNC_STAGES(SYNC)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .ref_clk     (ref_clk),
        .ratio_sel   (ratio_sel),
        .ratio_valid (ratio_valid),
        .ref_active  (ref_active)
    );

    always #4 clk = ~clk;

    // Reference generator: programmable high/low lengths in clk cycles
    int hi_len = 0;
    int lo_len = 0;
    int phase_cnt = 0;
    always @(negedge clk) begin
        if (hi_len == 0 || lo_len == 0) begin
            ref_clk = 1'b0;
            phase_cnt = 0;
        end else begin
            phase_cnt++;
            if (ref_clk && phase_cnt >= hi_len) begin
                ref_clk = 1'b0;
                phase_cnt = 0;
            end else if (!ref_clk && phase_cnt >= lo_len) begin
                ref_clk = 1'b1;
                phase_cnt = 0;
            end
        end
    end

    // Behavioural reference model
    int  seen[$];
    int  m_acc, m_tick, m_res, m_cand, m_sel;
    bit  m_done, m_valid, m_active, m_ready;

    function automatic int band_of(int n);
        if (n == 0) return 3;
        if (n > HI) return 0;
        if (n > LO) return 1;
        return 2;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            seen = {};
            for (int i = 0; i <= SYNC; i++) seen.push_back(0);
            m_acc = 0; m_tick = 0; m_res = 0; m_done = 0;
            m_cand = 3; m_sel = 3; m_valid = 0; m_active = 0;
            m_ready = 1;
        end else begin
            if (m_done) begin
                int b;
                b = band_of(m_res);
                if (b == 3) begin
                    m_sel = 3; m_valid = 0; m_active = 0;
                end else begin
                    m_active = 1;
                    if (b == m_cand) begin m_sel = b; m_valid = 1; end
                end
                m_cand = b;
            end
            if (seen[SYNC-1] == 1 && seen[SYNC] == 0) m_acc++;
            if (m_tick == WIN - 1) begin
                m_done = 1; m_res = m_acc; m_acc = 0; m_tick = 0;
            end else begin
                m_done = 0; m_tick++;
            end
            seen.push_front(int'(ref_clk));
            void'(seen.pop_back());
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && m_ready) begin
            compared++;
            if (int'(ratio_sel) != m_sel) begin
                mismatched++;
                $display("FAIL R2 ratio_sel actual=%0d expected=%0d at %0t", ratio_sel, m_sel, $time);
            end
            compared++;
            if (ratio_valid != m_valid) begin
                mismatched++;
                $display("FAIL R9 ratio_valid actual=%0d expected=%0d at %0t", ratio_valid, m_valid, $time);
            end
            compared++;
            if (ref_active != m_active) begin
                mismatched++;
                $display("FAIL R7 ref_active actual=%0d expected=%0d at %0t", ref_active, m_active, $time);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ref(input int h, input int l);
        @(posedge clk);
        hi_len = h;
        lo_len = l;
    endtask

    task automatic expect_band(input string req, input int sel);
        check(int'(ratio_sel) == sel, req, int'(ratio_sel), sel);
        check(ratio_valid == 1'b1, req, int'(ratio_valid), 1);
        check(ref_active == 1'b1, req, int'(ref_active), 1);
    endtask

    initial begin
        #(8 * 200000);
        mismatched++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int t_act, t_val, t;
        bit got_act, got_val;
        int dev;

        cycles(10);
        // R1 reset state
        check(ratio_sel == 2'b11, "R1 sel in reset", int'(ratio_sel), 3);
        check(!ratio_valid, "R1 valid in reset", int'(ratio_valid), 0);
        check(!ref_active, "R1 active in reset", int'(ref_active), 0);
        @(posedge clk); rst = 1'b0;
        cycles(WIN + 8);
        check(ratio_sel == 2'b11 && !ref_active, "R1 idle after reset", int'(ratio_sel), 3);

        // R3: period 4 -> 64 edges per window
        set_ref(2, 2); cycles(4 * WIN);
        expect_band("R3 period4", 0);
        // R4 and R10: period 8 -> 32 edges
        set_ref(4, 4); cycles(4 * WIN);
        expect_band("R4 R10 period8", 1);
        // R5: period 32 -> 8 edges
        set_ref(16, 16); cycles(4 * WIN);
        expect_band("R5 period32", 2);
        // Boundary around the upper threshold
        set_ref(3, 2); cycles(4 * WIN);
        expect_band("R3 period5 count51", 0);
        set_ref(3, 3); cycles(4 * WIN);
        expect_band("R4 period6 count42", 1);
        // Boundary around the lower threshold
        set_ref(8, 7); cycles(4 * WIN);
        expect_band("R4 period15 count17", 1);
        set_ref(8, 8); cycles(4 * WIN);
        expect_band("R5 period16 count16", 2);

        // R6: half-window burst of fast reference inside a steady period-8 reference
        set_ref(4, 4); cycles(4 * WIN);
        expect_band("R6 pre-burst", 1);
        set_ref(2, 2);
        dev = 0;
        for (int i = 0; i < WIN / 2; i++) begin
            @(negedge clk);
            if (ratio_sel != 2'b01) dev++;
        end
        set_ref(4, 4);
        for (int i = 0; i < 3 * WIN; i++) begin
            @(negedge clk);
            if (ratio_sel != 2'b01) dev++;
        end
        check(dev == 0, "R6 burst ignored", dev, 0);

        // R7: reference stops
        set_ref(0, 0); cycles(2 * WIN + 8);
        check(!ref_active, "R7 active low", int'(ref_active), 0);
        check(ratio_sel == 2'b11, "R7 sel none", int'(ratio_sel), 3);
        check(!ratio_valid, "R7 valid low", int'(ratio_valid), 0);

        // R8: reference resumes at an arbitrary phase
        cycles(37);
        set_ref(4, 4);
        got_act = 0; got_val = 0; t_act = 0; t_val = 0;
        for (t = 0; t < 5 * WIN; t++) begin
            @(negedge clk);
            if (!got_act && ref_active) begin got_act = 1; t_act = t; end
            if (!got_val && ratio_valid) begin got_val = 1; t_val = t; end
        end
        check(got_act && t_act <= WIN + 4, "R8 active returns", t_act, WIN);
        check(got_val && (t_val - t_act) >= WIN && ((t_val - t_act) % WIN) == 0,
              "R8 valid after whole windows", t_val - t_act, WIN);
        expect_band("R8 R10 recovered band", 1);

        // R1: reset in the middle of activity
        @(posedge clk); rst = 1'b1;
        cycles(3);
        check(ratio_sel == 2'b11 && !ratio_valid && !ref_active, "R1 mid-run reset",
              int'(ratio_sel), 3);
        @(posedge clk); rst = 1'b0;
        cycles(4 * WIN);
        expect_band("R10 after reset", 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule